// File: doc/BRIEF.md
# Processor Reset Supervisor

This controller drives a processor's reset from three sources: a supply-good flag coming from an external threshold comparator, an active-low manual reset pin, and a watchdog input. It presents the result on two pins that are always complements of each other: an active-low reset and an active-high reset. Whenever any source calls for reset, reset is asserted. It is then held for one full hold-off period after the last request goes away.

The hold-off period is a count of prescaled clock ticks, so one parameter sets the tick length and a second sets the number of ticks. The hold-off timer has its own prescaler, and both restart on every request. A release therefore always comes exactly `HOLD_TICKS*CLK_DIV` clocks after the last clock that saw a request.

The manual pin passes through a two-flop synchroniser and then a debounce stage. The debounce stage accepts a new level only after it has been steady for `DEB_TICKS` ticks. When `WDOG_EN` is set, a missing edge on the watchdog input for `WDOG_TICKS` ticks causes one reset pulse of hold-off length. The watchdog window is cleared while reset is asserted, so it starts afresh at every release. The supply-good flag is taken as already synchronous.

Top module: `reset_supervisor`

## Requirements
- R1: A low `supply_ok` sampled at a rising clock edge makes `rst_out_n` low after that same edge.
- R2: After the last edge that samples a reset request, `rst_out_n` goes high exactly `HOLD_TICKS*CLK_DIV` clock edges later, provided no new request appears in between.
- R3: A fresh supply drop during a hold-off already in progress restarts the full hold-off, counted from the new drop.
- R4: A debounced low on `mr_n` asserts reset and keeps it asserted while the pin stays low. Release follows the debounced return to high by the full hold-off; sync and debounce add between 2 and `2+DEB_TICKS*CLK_DIV` clocks.
- R5: A low pulse on `mr_n` shorter than `DEB_TICKS` prescaler ticks has no effect on the reset outputs.
- R6: `rst_out` is the exact inverse of `rst_out_n` in every cycle.
- R7: While `rst_n` is low, reset is asserted. After `rst_n` rises with the supply good and `mr_n` high, reset stays asserted for exactly `HOLD_TICKS*CLK_DIV` clocks.
- R8: With `WDOG_EN` set and reset released, `WDOG_TICKS` ticks without any edge on `wdog_in` cause a reset lasting exactly one hold-off. Edges arriving more often than this keep reset released.
- R9: The watchdog window is held cleared while reset is asserted. After a release, the next watchdog reset therefore comes no sooner than `(WDOG_TICKS-1)*CLK_DIV` clocks and no later than `WDOG_TICKS*CLK_DIV+1` clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| supply_ok | input | 1 | Synchronous supply-good flag; low requests reset |
| mr_n | input | 1 | Asynchronous active-low manual reset request |
| wdog_in | input | 1 | Watchdog input; any edge restarts the window |
| rst_out_n | output | 1 | Active-low processor reset |
| rst_out | output | 1 | Active-high processor reset, inverse of `rst_out_n` |

## Verification
The bench measures the hold-off to the exact clock after a single drop and after a second drop that lands mid-timeout. A timer that does not reload would release early, and one that restarts only its tick counter and not its prescaler would release up to one tick off. A short manual glitch must leave reset untouched, which catches a missing or too-short debounce. A long press must hold reset for its whole duration and then for the full timeout. The watchdog is starved on purpose to check both the pulse length and the spacing to the next pulse: a window that is not cleared during reset fires again too soon after the release.

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
  parameter int CLK_DIV    = 50000,
  parameter int HOLD_TICKS = 200,
  parameter int DEB_TICKS  = 10,
  parameter bit WDOG_EN    = 1'b1,
  parameter int WDOG_TICKS = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic mr_n,
  input  logic wdog_in,
  output logic rst_out_n,
  output logic rst_out
);

  localparam int PW = (CLK_DIV    > 1) ? $clog2(CLK_DIV)    : 1;
  localparam int HW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
  localparam int DW = (DEB_TICKS  > 1) ? $clog2(DEB_TICKS)  : 1;
  localparam int WW = (WDOG_TICKS > 1) ? $clog2(WDOG_TICKS) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(CLK_DIV - 1);
  localparam logic [HW-1:0] H_LAST = HW'(HOLD_TICKS - 1);
  localparam logic [DW-1:0] D_LAST = DW'(DEB_TICKS - 1);
  localparam logic [WW-1:0] W_LAST = WW'(WDOG_TICKS - 1);

  logic [PW-1:0] pre_cnt;
  logic          tick;
  logic [1:0]    mr_sync;
  logic          mr_s2;
  logic          mr_db;
  logic [DW-1:0] deb_cnt;
  logic [WW-1:0] wd_cnt;
  logic          wd_fire;
  logic [PW-1:0] hold_pre;
  logic [HW-1:0] hold_cnt;
  logic          active;
  logic          cause;

  // free-running tick shared by debounce and watchdog
  assign tick = (pre_cnt == P_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= tick ? '0 : pre_cnt + 1'b1;

  // manual reset: synchronise, then demand a steady level
  assign mr_s2 = mr_sync[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mr_sync <= 2'b11;
    else        mr_sync <= {mr_sync[0], mr_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mr_db   <= 1'b1;
      deb_cnt <= '0;
    end else if (mr_s2 == mr_db) begin
      deb_cnt <= '0;
    end else if (tick) begin
      if (deb_cnt == D_LAST) begin
        mr_db   <= mr_s2;
        deb_cnt <= '0;
      end else begin
        deb_cnt <= deb_cnt + 1'b1;
      end
    end

  generate
    if (WDOG_EN) begin : g_wdog
      logic [2:0] wd_sync;
      logic       wd_edge;

      assign wd_edge = wd_sync[2] ^ wd_sync[1];
      assign wd_fire = ~active & tick & ~wd_edge & (wd_cnt == W_LAST);

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) wd_sync <= '0;
        else        wd_sync <= {wd_sync[1:0], wdog_in};

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                wd_cnt <= '0;
        else if (active | wd_edge) wd_cnt <= '0;
        else if (tick)             wd_cnt <= (wd_cnt == W_LAST) ? '0 : wd_cnt + 1'b1;
    end else begin : g_no_wdog
      logic unused_wd;
      assign unused_wd = wdog_in;
      assign wd_fire   = 1'b0;
      assign wd_cnt    = '0;
    end
  endgenerate

  // hold-off: own prescaler so every request restarts a whole period
  assign cause = ~supply_ok | ~mr_db | wd_fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active   <= 1'b1;
      hold_pre <= '0;
      hold_cnt <= '0;
    end else if (cause) begin
      active   <= 1'b1;
      hold_pre <= '0;
      hold_cnt <= '0;
    end else if (active) begin
      if (hold_pre == P_LAST) begin
        hold_pre <= '0;
        if (hold_cnt == H_LAST) begin
          hold_cnt <= '0;
          active   <= 1'b0;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end else begin
        hold_pre <= hold_pre + 1'b1;
      end
    end

  assign rst_out_n = ~active;
  assign rst_out   = active;

endmodule

// File: rtl/reset_supervisor_chk.sv
module reset_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic rst_out_n,
  input logic rst_out,
  input logic mr_s2,
  input logic mr_db,
  input logic wd_zero
);

  p_complement_r6: assert property (@(posedge clk) rst_out == ~rst_out_n);

  p_supply_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !rst_out_n);

  p_release_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> ($past(supply_ok) && $past(mr_db)));

  p_deb_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_db != $past(mr_db)) |-> ($past(mr_s2) == mr_db));

  p_wd_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |=> wd_zero);

endmodule

bind reset_supervisor reset_supervisor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .supply_ok (supply_ok),
  .rst_out_n (rst_out_n),
  .rst_out   (rst_out),
  .mr_s2     (mr_s2),
  .mr_db     (mr_db),
  .wd_zero   (wd_cnt == '0)
);

// File: tb/tb_reset_supervisor.sv
module tb_reset_supervisor;
  localparam int DIV   = 4;
  localparam int HOLD  = 5;
  localparam int DEB   = 3;
  localparam int WD    = 8;
  localparam int HOLDC = HOLD * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1;
  logic mr_n = 1'b1;
  logic wdog_in = 1'b0;
  logic rst_out_n, rst_out;
  logic kick = 1'b1;
  int   kc = 0;
  int   total = 0;
  int   bad = 0;
  string cur = "R7";

  reset_supervisor #(.CLK_DIV(DIV), .HOLD_TICKS(HOLD), .DEB_TICKS(DEB),
                     .WDOG_EN(1'b1), .WDOG_TICKS(WD)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mr_n(mr_n),
    .wdog_in(wdog_in), .rst_out_n(rst_out_n), .rst_out(rst_out));

  always #5 clk = ~clk;

  // behavioural reference: time since last request, debounce by counting
  int m_pcnt = 0, m_dcnt = 0, m_wcnt = 0, m_since = 0;
  bit m_s1 = 1, m_s2 = 1, m_db = 1, m_w1 = 0, m_w2 = 0, m_w3 = 0, m_act = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pcnt = 0; m_dcnt = 0; m_wcnt = 0; m_since = 0;
      m_s1 = 1; m_s2 = 1; m_db = 1; m_w1 = 0; m_w2 = 0; m_w3 = 0; m_act = 1;
    end else begin
      bit t, e, f, req, old_act;
      t = (m_pcnt == DIV - 1);
      e = (m_w2 != m_w3);
      old_act = m_act;
      f = !old_act && t && (m_wcnt == WD - 1) && !e;
      req = !supply_ok || !m_db || f;
      if (req) m_since = 0;
      else if (m_since < HOLDC) m_since++;
      m_act = (m_since < HOLDC);
      if (old_act || e) m_wcnt = 0;
      else if (t) m_wcnt = (m_wcnt == WD - 1) ? 0 : m_wcnt + 1;
      if (m_s2 == m_db) m_dcnt = 0;
      else if (t) begin
        if (m_dcnt == DEB - 1) begin m_db = m_s2; m_dcnt = 0; end
        else m_dcnt++;
      end
      m_s2 = m_s1; m_s1 = mr_n;
      m_w3 = m_w2; m_w2 = m_w1; m_w1 = wdog_in;
      m_pcnt = t ? 0 : m_pcnt + 1;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk(rst_out_n == !m_act, cur, int'(rst_out_n), int'(!m_act));
    chk(rst_out == ~rst_out_n, "R6", int'(rst_out), int'(~rst_out_n));
  end

  always @(negedge clk) if (kick) begin
    kc++;
    if (kc % 8 == 0) wdog_in = ~wdog_in;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!rst_out_n && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (rst_out_n && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n, lows;
    step(5);
    chk(rst_out_n == 1'b0, "R7", int'(rst_out_n), 0);
    rst_n = 1'b1;
    count_low(n);
    chk(n == HOLDC, "R7", n, HOLDC);

    cur = "R1"; step(10);
    supply_ok = 1'b0; step(1);
    chk(rst_out_n == 1'b0, "R1", int'(rst_out_n), 0);
    step(3); cur = "R2"; supply_ok = 1'b1;
    count_low(n);
    chk(n == HOLDC, "R2", n, HOLDC);

    cur = "R3"; step(5);
    supply_ok = 1'b0; step(2); supply_ok = 1'b1; step(12);
    chk(rst_out_n == 1'b0, "R3", int'(rst_out_n), 0);
    supply_ok = 1'b0; step(1); supply_ok = 1'b1;
    count_low(n);
    chk(n == HOLDC, "R3", n, HOLDC);

    cur = "R5"; step(10);
    mr_n = 1'b0; step(3); mr_n = 1'b1;
    lows = 0;
    for (int i = 0; i < 40; i++) begin step(1); if (!rst_out_n) lows++; end
    chk(lows == 0, "R5", lows, 0);

    cur = "R4"; mr_n = 1'b0; step(30);
    chk(rst_out_n == 1'b0, "R4", int'(rst_out_n), 0);
    mr_n = 1'b1;
    count_low(n);
    chk(n >= HOLDC + 2 && n <= HOLDC + 3 + DEB * DIV, "R4", n, HOLDC + 2);

    cur = "R8"; step(5); kick = 1'b0;
    count_high(n);
    chk(rst_out_n == 1'b0, "R8", int'(rst_out_n), 0);
    count_low(n);
    chk(n == HOLDC, "R8", n, HOLDC);
    cur = "R9";
    count_high(n);
    chk(n >= (WD - 1) * DIV && n <= WD * DIV + 1, "R9", n, WD * DIV);
    count_low(n);
    kick = 1'b1; cur = "R8";
    lows = 0;
    for (int i = 0; i < 100; i++) begin step(1); if (!rst_out_n) lows++; end
    chk(lows == 0, "R8", lows, 0);

    finish_run();
  end
endmodule